// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block collects 32 level-sensitive interrupt requests and steers each one onto one of 15 interrupt output lines. Software enables sources in an enable register and gives each source a 4-bit route code in one of four routing registers. A route code of zero leaves the source unconnected. An output line stays high for as long as at least one enabled, active source routed to it is high.

Each request first passes through a two-stage synchronizer. The synchronized levels can be read back from a read-only status register. The register port is a plain single-cycle interface. A write commits on the clock edge where select and write are both high. Read data is combinational from the addressed register.

Top module: `irq_router`

## Requirements
- R1: After reset the enable register and all four routing registers read zero, and every bit of `irq_out` is 0.
- R2: The enable register sits at byte offset 0x00 and holds the value written to it. Bit n set enables source n.
- R3: The status register at offset 0x04 returns `irq_in` as it was sampled two rising clock edges earlier.
- R4: Writes to offset 0x04 have no effect. The status register still shows the synchronized inputs, and the enable register is unchanged.
- R5: The routing registers sit at offsets 0x08, 0x0C, 0x10 and 0x14, and their order runs opposite to source number. Offset 0x08 holds sources 24–31 and offset 0x14 holds sources 0–7. Within a register, source n occupies bits [4*(n mod 8)+3 : 4*(n mod 8)]. The registers read back what was written.
- R6: A source whose route code is 0 drives no output.
- R7: A source with route code c (1..15) drives output bit c-1 when it is pending. Pending means its synchronized status bit and its enable bit are both 1.
- R8: A source whose enable bit is 0 drives no output, whatever its level and route code.
- R9: An output bit is the OR of all pending sources routed to it.
- R10: Reads of offsets above 0x14 return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write enable, qualified by `reg_sel` |
| reg_addr | input | 8 | Byte offset, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_in | input | 32 | Level interrupt requests |
| irq_out | output | 15 | Routed interrupt lines |

## Verification
The assertions assume the following about the inputs:
- `reg_addr` is word aligned whenever `reg_sel` is high.
- `irq_in` is held at zero while reset is asserted, so the synchronizer never holds stale levels.

The bench drives every access at the falling edge. It only uses word-aligned offsets, and it changes `irq_in` only outside reset, then waits two full cycles before it compares status or outputs. The random patterns for enables, routes and levels are checked against a model of route decoding and OR-reduction written in the bench.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int DEF_NUM_IN  = 32;
    localparam int DEF_CODE_W  = 4;
    localparam int DEF_NUM_OUT = 15;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_ADDR_W  = 8;

    // Word indices of the register window (byte offset / 4)
    localparam int WIDX_ENABLE = 0;
    localparam int WIDX_STATUS = 1;
    localparam int WIDX_ROUTE0 = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = din;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.stable;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int NUM_IN = DEF_NUM_IN,
    parameter int CODE_W = DEF_CODE_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NUM_IN-1:0]        status,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_IN-1:0]        enable,
    output logic [NUM_IN*CODE_W-1:0] route
);
    localparam int ROUTE_BITS = NUM_IN * CODE_W;
    localparam int ROUTE_REGS = ROUTE_BITS / DATA_W;

    typedef struct packed {
        logic [NUM_IN-1:0]     enable;
        logic [ROUTE_BITS-1:0] route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    int   widx;
    int   rslot;

    always_comb begin
        widx  = int'(addr[ADDR_W-1:2]);
        rslot = ROUTE_REGS - 1 - (widx - WIDX_ROUTE0);
        cfg_d = cfg_q;
        if (sel && we) begin
            if (widx == WIDX_ENABLE) begin
                cfg_d.enable = wdata[NUM_IN-1:0];
            end else if (widx >= WIDX_ROUTE0 && widx < WIDX_ROUTE0 + ROUTE_REGS) begin
                cfg_d.route[rslot*DATA_W +: DATA_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (widx == WIDX_ENABLE) begin
            rdata[NUM_IN-1:0] = cfg_q.enable;
        end else if (widx == WIDX_STATUS) begin
            rdata[NUM_IN-1:0] = status;
        end else if (widx >= WIDX_ROUTE0 && widx < WIDX_ROUTE0 + ROUTE_REGS) begin
            rdata = cfg_q.route[rslot*DATA_W +: DATA_W];
        end
    end

    assign enable = cfg_q.enable;
    assign route  = cfg_q.route;
endmodule

// File: rtl/irq_route_or.sv
module irq_route_or #(
    parameter int NUM_IN  = 32,
    parameter int CODE_W  = 4,
    parameter int NUM_OUT = 15
) (
    input  logic [NUM_IN-1:0]        status,
    input  logic [NUM_IN-1:0]        enable,
    input  logic [NUM_IN*CODE_W-1:0] route,
    output logic [NUM_OUT-1:0]       lines
);
    logic [NUM_IN-1:0] pending;
    assign pending = status & enable;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
        logic [NUM_IN-1:0] hit;
        for (genvar n = 0; n < NUM_IN; n++) begin : g_src
            assign hit[n] = pending[n] && (route[n*CODE_W +: CODE_W] == CODE_W'(k + 1));
        end
        assign lines[k] = |hit;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int CODE_W  = DEF_CODE_W,
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_IN-1:0]  irq_in,
    output logic [NUM_OUT-1:0] irq_out
);
    logic [NUM_IN-1:0]        status_w;
    logic [NUM_IN-1:0]        enable_w;
    logic [NUM_IN*CODE_W-1:0] route_w;

    irq_sync #(.W(NUM_IN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (status_w)
    );

    irq_regfile #(
        .NUM_IN(NUM_IN), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (reg_sel),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .status(status_w),
        .rdata (reg_rdata),
        .enable(enable_w),
        .route (route_w)
    );

    irq_route_or #(
        .NUM_IN(NUM_IN), .CODE_W(CODE_W), .NUM_OUT(NUM_OUT)
    ) u_or (
        .status(status_w),
        .enable(enable_w),
        .route (route_w),
        .lines (irq_out)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int CODE_W  = DEF_CODE_W,
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_sel,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [NUM_IN-1:0]        irq_in,
    input logic [NUM_OUT-1:0]       irq_out,
    input logic [NUM_IN-1:0]        status_w,
    input logic [NUM_IN-1:0]        enable_w,
    input logic [NUM_IN*CODE_W-1:0] route_w
);
    localparam int ROUTE_REGS = NUM_IN * CODE_W / DATA_W;
    localparam int LAST_WIDX  = WIDX_ROUTE0 + ROUTE_REGS - 1;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    logic wr_en, wr_route, rd_unmapped;
    assign wr_en       = reg_sel && reg_we && int'(reg_addr[ADDR_W-1:2]) == WIDX_ENABLE;
    assign wr_route    = reg_sel && reg_we && int'(reg_addr[ADDR_W-1:2]) >= WIDX_ROUTE0
                                           && int'(reg_addr[ADDR_W-1:2]) <= LAST_WIDX;
    assign rd_unmapped = int'(reg_addr[ADDR_W-1:2]) > LAST_WIDX;

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> enable_w == $past(reg_wdata[NUM_IN-1:0]));

    assert_enable_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable_w));

    assert_route_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_route |=> $stable(route_w));

    assert_status_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd3 |-> status_w == $past(irq_in, 2));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |-> reg_rdata == '0);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable_w == '0 |-> irq_out == '0);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w & enable_w) == '0 |-> irq_out == '0);
endmodule

bind irq_router irq_router_chk #(
    .NUM_IN(NUM_IN), .CODE_W(CODE_W), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_in = '0;
    logic [14:0] irq_out;

    int checks = 0;
    int fails  = 0;

    logic [31:0]  m_enable = '0;
    logic [127:0] m_route  = '0;
    logic [31:0]  m_irq    = '0;

    always #4 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [14:0] exp_lines(input logic [31:0] en, input logic [31:0] lv,
                                              input logic [127:0] rt);
        logic [14:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            logic [3:0] c = rt[4*n +: 4];
            if (en[n] && lv[n] && c != 4'd0) r[c - 4'd1] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        if (a == 8'h00) m_enable = d;
        else if (a >= 8'h08 && a <= 8'h14) m_route[32*(3 - (a - 8'h08)/4) +: 32] = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic drive_irq(input logic [31:0] v);
        @(negedge clk);
        irq_in = v; m_irq = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req);
        check(req, {17'd0, irq_out}, {17'd0, exp_lines(m_enable, m_irq, m_route)});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        process::self().srandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 out", {17'd0, irq_out}, 32'd0);
        rd(8'h00, v); check("R1 enable", v, 32'd0);
        for (int a = 8; a <= 20; a += 4) begin
            rd(8'(a), v); check("R1 route", v, 32'd0);
        end

        // R2: enable register
        wr(8'h00, 32'hA5A5_0F0F);
        rd(8'h00, v); check("R2 enable", v, 32'hA5A5_0F0F);

        // R3: status latency
        drive_irq(32'h1234_5678);
        rd(8'h04, v); check("R3 status", v, 32'h1234_5678);
        @(negedge clk); irq_in = 32'hFFFF_0000;
        @(negedge clk); #1 begin
            // only one rising edge since change
            reg_sel = 1'b0;
        end
        rd(8'h04, v); check("R3 status two edges", v, 32'hFFFF_0000);
        m_irq = 32'hFFFF_0000;

        // R4: status write ignored
        wr(8'h04, 32'h0000_FFFF);
        rd(8'h04, v); check("R4 status", v, 32'hFFFF_0000);
        rd(8'h00, v); check("R4 enable", v, 32'hA5A5_0F0F);

        // R5: inverted order and field position
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h0000_000F);
        wr(8'h14, 32'h1000_0001);
        rd(8'h08, v); check("R5 rb08", v, 32'h0000_000F);
        rd(8'h14, v); check("R5 rb14", v, 32'h1000_0001);
        wr(8'h00, 32'h0100_0000);
        drive_irq(32'h0100_0000);
        check("R5 src24->line14", {17'd0, irq_out}, 32'h0000_4000);
        wr(8'h00, 32'h0000_0081);
        drive_irq(32'h0000_0081);
        check("R5 src0,7->line0", {17'd0, irq_out}, 32'h0000_0001);

        // R6: code 0 disconnects
        wr(8'h14, 32'h0000_0000);
        check("R6 disconnected", {17'd0, irq_out}, 32'd0);

        // R7: code c drives line c-1; R9 OR of two sources
        wr(8'h10, 32'h0000_0050);
        wr(8'h0C, 32'h0000_0005);
        wr(8'h00, 32'h0001_0200);
        drive_irq(32'h0001_0200);
        check("R7 code5->line4", {17'd0, irq_out}, 32'h0000_0010);
        drive_irq(32'h0000_0200);
        check("R9 one of two", {17'd0, irq_out}, 32'h0000_0010);
        drive_irq(32'h0000_0000);
        check("R9 none", {17'd0, irq_out}, 32'd0);

        // R8: masked source
        drive_irq(32'h0001_0200);
        wr(8'h00, 32'h0);
        check("R8 masked", {17'd0, irq_out}, 32'd0);

        // R10: unmapped offsets
        wr(8'h18, 32'hDEAD_BEEF);
        wr(8'hFC, 32'hDEAD_BEEF);
        rd(8'h18, v); check("R10 read18", v, 32'd0);
        rd(8'hFC, v); check("R10 readFC", v, 32'd0);
        rd(8'h00, v); check("R10 enable kept", v, 32'd0);
        rd(8'h08, v); check("R10 route kept", v, 32'h0000_000F);

        // Random mix: R7 R8 R9 R3
        for (int it = 0; it < 200; it++) begin
            wr(8'h00, $urandom);
            for (int r = 0; r < 4; r++) begin
                logic [31:0] d = $urandom;
                if ($urandom_range(0, 3) == 0) d = d & 32'h0F0F_0F0F;
                wr(8'(8 + 4*r), d);
            end
            drive_irq($urandom);
            check_out("R9 random");
            rd(8'h04, v); check("R3 random status", v, m_irq);
        end

        finish_run();
    end
endmodule